// File: doc/BRIEF.md
# Dual-Counter Multi-Mode Timer

This block holds two 16-bit down-counters and two 16-bit registers, A and B. It also has two event pins, A and B. A two-bit mode field decides what the registers and pins do. In PWM mode, counter 1 and both registers produce a pulse train on pin A. In dual-capture mode, edges on the two pins copy counter 1 into A and B, so software can measure the interval between two external events. In dual-timer mode, each counter reloads from its own register. In single-capture mode, pin A captures counter 1, while counter 2 runs as a timer that can count pin B edges.

Software reaches the block through a small register port with a write strobe, an address, write data and a combinational read bus. Each counter advances on a per-counter tick input, which comes from an external prescaler, or on synchronized pin edges. Two interrupt lines report the sticky pending flags. Pin multiplexing and the prescaler itself sit outside the block.

Top module: `mtm_timer`

## Requirements
- R1: Register map: 0 control, 1 status, 2 register A, 3 register B, 4 counter 1, 5 counter 2. Control bits: [1:0] mode (0 dual timers, 1 PWM, 2 dual capture, 3 single capture plus timer), [2] run1, [3] run2, [4] polarity A, [5] polarity B, [6] external clock 1, [7] external clock 2, [8] interrupt enable A, [9] interrupt enable B. Writing a counter address loads that counter. After reset, every register reads 0 and every output is low. pin_a_oe is high only in PWM mode.
- R2: In PWM mode with B < A, pin A rises on each underflow of counter 1 and falls on the tick where counter 1 steps to the value of B. It stays high for A−B ticks out of every A+1.
- R3: In dual-timer mode, a counter that is 0 on an enabled tick reloads from its register (counter 1 from A, counter 2 from B) and sets its pending flag. The period is therefore register+1 ticks.
- R4: In dual-capture mode, the selected edge on pin A copies counter 1 into A and sets pending A. The selected edge on pin B copies counter 1 into B and sets pending B. In single-capture mode, only pin A captures.
- R5: A counter that has no reload role in the current mode wraps from 0 to 0xFFFF.
- R6: With its external-clock bit set, counter 1 (dual-timer mode only) or counter 2 (dual-timer or single-capture mode) counts selected edges of its own pin instead of ticks.
- R7: A polarity bit of 0 selects rising edges and 1 selects falling edges. The other edge has no effect.
- R8: Status bit 0 is pending A and bit 1 is pending B. Writing 1 to a bit clears it, and a new event in the same cycle wins over the clear. Each interrupt output is its pending bit ANDed with its enable bit.
- R9: A control write that changes the mode clears both run bits and both pending flags. The counters keep their values.
- R10: Pin inputs pass through a two-flop synchronizer before edge detection. Edges of one polarity on a pin arrive at most once every four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| tick1 | input | 1 | Prescaled count enable for counter 1 |
| tick2 | input | 1 | Prescaled count enable for counter 2 |
| pin_a_i | input | 1 | Pin A input level |
| pin_b_i | input | 1 | Pin B input level |
| pin_a_o | output | 1 | Pin A output level (PWM) |
| pin_a_oe | output | 1 | Pin A output enable |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
The assertions assume that each pin delivers edges of one polarity no closer than four clocks apart. They also assume that software never changes a polarity bit while a pin is changing. The bench holds every pin pulse high for at least four clocks and low for at least four clocks, and it switches polarity only while the pins are idle. Random register values stay inside the PWM window B < A, and random capture intervals are kept to a few dozen clocks so that the measurements stay short.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
   typedef enum logic [1:0] {
      MODE_TIMERS = 2'd0,
      MODE_PWM    = 2'd1,
      MODE_CAP2   = 2'd2,
      MODE_CAP1   = 2'd3
   } mode_e;

   typedef struct packed {
      logic  ie_b;
      logic  ie_a;
      logic  ext2;
      logic  ext1;
      logic  pol_b;
      logic  pol_a;
      logic  run2;
      logic  run1;
      mode_e mode;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam logic [2:0] ADR_CTRL = 3'd0;
   localparam logic [2:0] ADR_STAT = 3'd1;
   localparam logic [2:0] ADR_REGA = 3'd2;
   localparam logic [2:0] ADR_REGB = 3'd3;
   localparam logic [2:0] ADR_CNT1 = 3'd4;
   localparam logic [2:0] ADR_CNT2 = 3'd5;
endpackage

// File: rtl/mtm_edge_sync.sv
module mtm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mtm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         last  <= 1'b0;
      end else begin
         shreg <= {shreg[STAGES-2:0], pin};
         last  <= shreg[STAGES-1];
      end
   end

   assign edge_o = fall_sel ? (last & ~shreg[STAGES-1])
                            : (~last & shreg[STAGES-1]);

   // R10: events no faster than one quarter of the clock
   assert_event_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |-> (!$past(edge_o, 1) && !$past(edge_o, 2) && !$past(edge_o, 3)));
endmodule

// File: rtl/mtm_downcnt.sv
module mtm_downcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         sw_load,
   input  logic [W-1:0] sw_val,
   input  logic         use_reload,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] cnt,
   output logic         uflow
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad
         $error("mtm_downcnt: W must be at least 2");
      end
   endgenerate

   assign uflow = en && !sw_load && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (sw_load)  cnt <= sw_val;
      else if (en)       cnt <= (cnt == '0) ? (use_reload ? reload_val : ALL_ONES)
                                            : cnt - W'(1);
   end

   // R3 / R5: underflow lands on the reload value or wraps to all ones
   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      uflow |=> cnt == $past(use_reload ? reload_val : ALL_ONES));
endmodule

// File: rtl/mtm_timer.sv
module mtm_timer
   import mtm_pkg::*;
#(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [2:0]   addr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   input  logic         tick1,
   input  logic         tick2,
   input  logic         pin_a_i,
   input  logic         pin_b_i,
   output logic         pin_a_o,
   output logic         pin_a_oe,
   output logic         irq_a,
   output logic         irq_b
);
   localparam int PAD_CTRL = W - CTRL_W;

   generate
      if (W < CTRL_W + 1) begin : g_bad
         $error("mtm_timer: W too narrow for the control register");
      end
   endgenerate

   ctrl_t        ctrl, ctrl_w;
   logic [W-1:0] reg_a, reg_b;
   logic         pend_a, pend_b, pwm_q;
   logic         wr_ctrl, wr_stat, mode_chg;
   logic [1:0]   pin_in, pol, ev, en, sw_load, use_rl, uflow;
   logic [W-1:0] rl_val [2];
   logic [W-1:0] cnt    [2];
   logic         cap_a, cap_b, set_a, set_b, pwm_fall;
   logic         is_tim, is_pwm, is_cap2, is_cap1;

   assign is_tim  = (ctrl.mode == MODE_TIMERS);
   assign is_pwm  = (ctrl.mode == MODE_PWM);
   assign is_cap2 = (ctrl.mode == MODE_CAP2);
   assign is_cap1 = (ctrl.mode == MODE_CAP1);

   assign wr_ctrl  = wr_en && (addr == ADR_CTRL);
   assign wr_stat  = wr_en && (addr == ADR_STAT);
   assign ctrl_w   = ctrl_t'(wdata[CTRL_W-1:0]);
   assign mode_chg = wr_ctrl && (ctrl_w.mode != ctrl.mode);

   // pin synchronizers, one per pin
   assign pin_in = {pin_b_i, pin_a_i};
   assign pol    = {ctrl.pol_b, ctrl.pol_a};
   for (genvar i = 0; i < 2; i++) begin : g_pin
      mtm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
         .fall_sel(pol[i]), .edge_o(ev[i]));
   end

   // count enables and reload roles per mode
   assign en[0] = ctrl.run1 && ((is_tim && ctrl.ext1) ? ev[0] : tick1);
   assign en[1] = ctrl.run2 && (((is_tim || is_cap1) && ctrl.ext2) ? ev[1] : tick2);
   assign use_rl[0] = is_tim || is_pwm;
   assign use_rl[1] = is_tim || is_cap1;
   assign rl_val[0] = reg_a;
   assign rl_val[1] = reg_b;
   assign sw_load[0] = wr_en && (addr == ADR_CNT1);
   assign sw_load[1] = wr_en && (addr == ADR_CNT2);

   for (genvar i = 0; i < 2; i++) begin : g_cnt
      mtm_downcnt #(.W(W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .en(en[i]), .sw_load(sw_load[i]),
         .sw_val(wdata), .use_reload(use_rl[i]), .reload_val(rl_val[i]),
         .cnt(cnt[i]), .uflow(uflow[i]));
   end

   assign cap_a = (is_cap2 || is_cap1) && ev[0];
   assign cap_b = is_cap2 && ev[1];
   assign set_a = cap_a || (uflow[0] && (is_tim || is_pwm));
   assign set_b = cap_b || (uflow[1] && (is_tim || is_cap1));
   assign pwm_fall = en[0] && !sw_load[0] && (cnt[0] != '0) &&
                     ((cnt[0] - W'(1)) == reg_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl <= ctrl_w;
         if (mode_chg) begin
            ctrl.run1 <= 1'b0;
            ctrl.run2 <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a <= '0;
         reg_b <= '0;
      end else begin
         if (cap_a)                              reg_a <= cnt[0];
         else if (wr_en && (addr == ADR_REGA))   reg_a <= wdata;
         if (cap_b)                              reg_b <= cnt[0];
         else if (wr_en && (addr == ADR_REGB))   reg_b <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_a <= 1'b0;
         pend_b <= 1'b0;
      end else if (mode_chg) begin
         pend_a <= 1'b0;
         pend_b <= 1'b0;
      end else begin
         pend_a <= set_a || (pend_a && !(wr_stat && wdata[0]));
         pend_b <= set_b || (pend_b && !(wr_stat && wdata[1]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pwm_q <= 1'b0;
      else if (mode_chg || !is_pwm) pwm_q <= 1'b0;
      else if (uflow[0])            pwm_q <= 1'b1;
      else if (pwm_fall)            pwm_q <= 1'b0;
   end

   assign pin_a_o  = pwm_q;
   assign pin_a_oe = is_pwm;
   assign irq_a    = pend_a && ctrl.ie_a;
   assign irq_b    = pend_b && ctrl.ie_b;

   always_comb begin
      unique case (addr)
         ADR_CTRL: rdata = {{PAD_CTRL{1'b0}}, ctrl};
         ADR_STAT: rdata = {{(W-2){1'b0}}, pend_b, pend_a};
         ADR_REGA: rdata = reg_a;
         ADR_REGB: rdata = reg_b;
         ADR_CNT1: rdata = cnt[0];
         ADR_CNT2: rdata = cnt[1];
         default:  rdata = '0;
      endcase
   end

   // R9: a mode change stops both counters and drops pending flags
   assert_mode_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (!pend_a && !pend_b && !ctrl.run1 && !ctrl.run2));
   // R4: capture copies the counter value of the capture cycle
   assert_capture_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_a |=> (reg_a == $past(cnt[0])));
   // R2: an underflow in PWM mode raises pin A
   assert_pwm_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pwm && uflow[0] && !mode_chg) |=> pin_a_o);
   // R1: pin A only driven high while its output is enabled
   assert_pin_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pin_a_o |-> pin_a_oe);
endmodule

// File: tb/mtm_timer_test.sv
module mtm_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        tick1 = 1'b0, tick2 = 1'b0;
   logic        pin_a_i = 1'b0, pin_b_i = 1'b0;
   logic        pin_a_o, pin_a_oe, irq_a, irq_b;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   mtm_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tick1(tick1), .tick2(tick2), .pin_a_i(pin_a_i),
      .pin_b_i(pin_b_i), .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe),
      .irq_a(irq_a), .irq_b(irq_b));

   function automatic logic [15:0] mk(int m, bit r1, bit r2, bit pa, bit pb,
                                      bit e1, bit e2, bit ia, bit ib);
      return 16'(m & 3) | (16'(r1) << 2) | (16'(r2) << 3) | (16'(pa) << 4) |
             (16'(pb) << 5) | (16'(e1) << 6) | (16'(e2) << 7) |
             (16'(ia) << 8) | (16'(ib) << 9);
   endfunction

   function automatic int pwm_high(int a, int b); return a - b; endfunction
   function automatic int pwm_period(int a);       return a + 1; endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] v);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic pulse(ref logic p);
      p = 1'b1; repeat (5) @(negedge clk);
      p = 1'b0; repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, v2;
      int n;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl reset", v, 0);
      rd(3'd1, v); chk("R1 stat reset", v, 0);
      rd(3'd4, v); chk("R1 cnt1 reset", v, 0);
      chk("R1 outputs reset", {pin_a_o, pin_a_oe, irq_a, irq_b}, 0);

      tick1 = 1'b1; tick2 = 1'b1;

      // R2 PWM with random register pairs
      for (int k = 0; k < 3; k++) begin
         int a, b, hi, per;
         a = $urandom_range(30, 6);
         b = $urandom_range(a - 1, 1);
         wr(3'd0, mk(0,0,0,0,0,0,0,0,0));
         wr(3'd4, 16'd0);
         wr(3'd2, 16'(a));
         wr(3'd3, 16'(b));
         wr(3'd0, mk(1,0,0,0,0,0,0,0,0));
         chk("R1 oe in PWM", pin_a_oe, 1);
         wr(3'd0, mk(1,1,0,0,0,0,0,0,0));
         n = 0;
         while (!pin_a_o && n < 500) begin @(negedge clk); n++; end
         hi = 0;
         while (pin_a_o && hi < 500) begin @(negedge clk); hi++; end
         per = hi;
         while (!pin_a_o && per < 500) begin @(negedge clk); per++; end
         chk("R2 pwm high ticks", hi, pwm_high(a, b));
         chk("R2 pwm period", per, pwm_period(a));
      end

      // R4 dual capture interval
      wr(3'd0, mk(0,0,0,0,0,0,0,0,0));
      chk("R1 oe off outside PWM", pin_a_oe, 0);
      wr(3'd0, mk(2,0,0,0,0,0,0,1,1));
      wr(3'd0, mk(2,1,0,0,0,0,0,1,1));
      begin
         int d;
         d = $urandom_range(60, 5);
         pin_a_i = 1'b1;
         repeat (d) @(negedge clk);
         pin_b_i = 1'b1;
         repeat (6) @(negedge clk);
         pin_a_i = 1'b0; pin_b_i = 1'b0;
         repeat (6) @(negedge clk);
         rd(3'd2, v); rd(3'd3, v2);
         chk("R4 capture interval", 16'(v - v2), 16'(d));
      end
      rd(3'd1, v); chk("R4 both pending", v, 3);
      chk("R8 irq lines", {irq_a, irq_b}, 2'b11);
      wr(3'd1, 16'd1);
      rd(3'd1, v); chk("R8 w1c clears only A", v, 2);
      wr(3'd1, 16'd2);
      rd(3'd1, v); chk("R8 w1c clears B", v, 0);

      // R5 wrap of counter 1 in capture mode
      wr(3'd0, mk(2,0,0,0,0,0,0,0,0));
      wr(3'd4, 16'd1);
      wr(3'd0, mk(2,1,0,0,0,0,0,0,0));
      repeat (2) @(negedge clk);
      tick1 = 1'b0;
      rd(3'd4, v); chk("R5 wrap to all ones", v, 16'hFFFF);

      // R7 falling polarity on pin B
      wr(3'd0, mk(2,1,0,0,1,0,0,0,0));
      wr(3'd4, 16'h0100);
      wr(3'd3, 16'h1234);
      pin_b_i = 1'b1; repeat (6) @(negedge clk);
      rd(3'd3, v); chk("R7 rising edge ignored", v, 16'h1234);
      rd(3'd1, v); chk("R7 no pending on wrong edge", v, 0);
      pin_b_i = 1'b0; repeat (6) @(negedge clk);
      rd(3'd3, v); chk("R7 falling edge captures", v, 16'h0100);
      rd(3'd1, v); chk("R7 pending B on falling edge", v, 2);

      // R9 mode change clears flags and run bits, counters hold
      wr(3'd0, mk(0,0,0,0,0,0,0,0,0));
      rd(3'd1, v); chk("R9 pending cleared", v, 0);
      rd(3'd0, v); chk("R9 run bits cleared", v, 0);
      tick1 = 1'b1;
      rd(3'd4, v); repeat (5) @(negedge clk); rd(3'd4, v2);
      chk("R9 counter holds", v2, v);

      // R3 dual timer period with random reload values
      for (int k = 0; k < 2; k++) begin
         int a;
         a = $urandom_range(20, 4);
         wr(3'd0, mk(0,0,0,0,0,0,0,1,0));
         wr(3'd1, 16'd3);
         wr(3'd4, 16'd0);
         wr(3'd2, 16'(a));
         wr(3'd0, mk(0,1,0,0,0,0,0,1,0));
         n = 0;
         while (!irq_a && n < 500) begin @(negedge clk); n++; end
         wr_en = 1'b1; addr = 3'd1; wdata = 16'd1;
         @(negedge clk); wr_en = 1'b0;
         n = 1;
         while (!irq_a && n < 500) begin @(negedge clk); n++; end
         chk("R3 reload period", n, a + 1);
      end
      wr(3'd0, mk(0,1,0,0,0,0,0,0,0));
      repeat (30) @(negedge clk);
      chk("R8 irq masked", irq_a, 0);
      rd(3'd1, v); chk("R8 pending still set", v[0], 1);

      // R6 counter 2 counts pin B edges
      wr(3'd0, mk(0,0,1,0,0,0,1,0,0));
      wr(3'd1, 16'd3);
      wr(3'd5, 16'd3);
      wr(3'd3, 16'd9);
      repeat (3) pulse(pin_b_i);
      rd(3'd5, v); chk("R6 three events counted", v, 0);
      rd(3'd1, v); chk("R6 no pending before underflow", v, 0);
      pulse(pin_b_i);
      rd(3'd1, v); chk("R6 pending on fourth event", v, 2);
      rd(3'd5, v); chk("R6 reload from B", v, 9);

      // R4 single capture mode: only pin A captures
      tick1 = 1'b0;
      wr(3'd0, mk(3,0,0,0,0,0,0,0,0));
      wr(3'd4, 16'h0042);
      pulse(pin_a_i);
      rd(3'd2, v); chk("R4 single capture A", v, 16'h0042);
      pulse(pin_b_i);
      rd(3'd3, v); chk("R4 pin B no capture", v, 9);
      rd(3'd1, v); chk("R4 single mode pending", v, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule